// File: doc/BRIEF.md
# Host-Target Mailbox Register Interface

This block gives a processor a two-register mailbox for talking to a host environment. The processor posts a 64-bit request through a 32-bit register bus, writing it as two halves. The block then decodes the request into a device number, a command and a payload. Device 0 reports the end of a test together with an exit code. Device 1 is a byte console. One of its commands sends a character out on a transmit stream. Another arms the mailbox so that the next character received from the host is posted back.

A request takes effect only when its upper half is written, and only when the preceding lower-half write found the request register empty. Once a request is processed the request register returns to zero, and in most cases a reply is placed in the second register. The reply carries the request's top 16 bits above a 48-bit response. The processor may also write the reply register directly, in two halves.

Top module: `host_mailbox`

## Requirements
- R1: After reset the request, reply and armed-read state are zero, every readable half reads zero, and exit_valid and con_tx_valid are low.
- R2: A request word holds the device in bits 63:56, the command in bits 55:48 and the payload in bits 47:0. Any processed request other than a console arm clears the request register and sets the reply register to the request's bits 63:48 above the 48-bit response.
- R3: A bus write to offset 0x0 (request low half) is accepted only when the full request register is zero. It then stores the data in bits 31:0 with bits 63:32 zero and sets the commit permission. Otherwise the request register is unchanged and the permission is cleared.
- R4: A bus write to offset 0x4 (request high half) ORs the data into bits 63:32. The merged request is processed only while the commit permission is set. Without the permission, the merged value stays in the request register, the reply is unchanged and no pulse is produced.
- R5: Device 0, command 0 with payload bit 0 set raises exit_valid for exactly one cycle, in the cycle after the committing write, with exit_code equal to the payload shifted right by one. The response is 0.
- R6: Device 1, command 1 raises con_tx_valid for one cycle, in the cycle after the committing write, with con_tx_byte equal to payload bits 7:0. The response is 0x100 plus that byte.
- R7: Device 1, command 0 saves the merged request as the armed read and clears the request register. The reply register is left unchanged.
- R8: Any other device or command, and device 0 command 0 with payload bit 0 clear, gives response 0 and no pulse.
- R9: A cycle with con_rx_valid high loads the reply register with the armed read's bits 63:48 above 0x100 plus con_rx_byte. This takes precedence over any bus update of the reply in the same cycle.
- R10: A bus write to offset 0x8 replaces the reply register with the data in bits 31:0 and zero above. A write to offset 0xC ORs the data into bits 63:32.
- R11: bus_rdata returns request bits 31:0, request bits 63:32, reply bits 31:0 or reply bits 63:32 at offsets 0x0, 0x4, 0x8 and 0xC. Every other address reads zero, and writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (4) | Byte offset of the accessed half |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Combinational read data for bus_addr |
| con_rx_valid | input | 1 | A console character has arrived |
| con_rx_byte | input | 8 | Arriving console character |
| con_tx_valid | output | 1 | One-cycle pulse per transmitted byte |
| con_tx_byte | output | 8 | Transmitted console character |
| exit_valid | output | 1 | One-cycle test completion pulse |
| exit_code | output | 2*BUS_W-17 (47) | Reported exit code |

## Verification
A wrong commit permission shows up as an accepted or refused request whose effect can be read back at offset 0x0 or 0x8 in the very next cycle. A miscoded device or command field shows up as a wrong reply top or response, or as a missing or extra pulse one cycle after the upper-half write. A stale armed read only becomes visible when a console character arrives, since the upper 16 bits of the reply then come from it. The sweep covers every small device and command value against several payload patterns, and a model in the bench restates the field rules to check each readable half after every operation.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  localparam int DEV_W  = 8;
  localparam int CMD_W  = 8;
  localparam int CHAR_W = 8;

  localparam int OFS_REQ_LO = 0;
  localparam int OFS_REQ_HI = 4;
  localparam int OFS_REP_LO = 8;
  localparam int OFS_REP_HI = 12;

  localparam logic [DEV_W-1:0] DEV_EXIT    = 8'd0;
  localparam logic [DEV_W-1:0] DEV_CONSOLE = 8'd1;
  localparam logic [CMD_W-1:0] CMD_ZERO    = 8'd0;
  localparam logic [CMD_W-1:0] CMD_ONE     = 8'd1;

  typedef enum logic [1:0] {
    ACT_REPLY = 2'd0,
    ACT_EXIT  = 2'd1,
    ACT_TX    = 2'd2,
    ACT_ARM   = 2'd3
  } hmb_act_e;

  // Console acknowledge: a set flag bit just above the character
  function automatic logic [CHAR_W:0] ack_char(input logic [CHAR_W-1:0] c);
    return {1'b1, c};
  endfunction
endpackage

// File: rtl/hmb_req_decode.sv
module hmb_req_decode
  import hmb_pkg::*;
#(
  parameter int WORD_W = 64,
  localparam int PAY_W = WORD_W - DEV_W - CMD_W
) (
  input  logic [WORD_W-1:0] req,
  output hmb_act_e          act,
  output logic [PAY_W-1:0]  resp,
  output logic [PAY_W-2:0]  code,
  output logic [CHAR_W-1:0] tx_char
);
  logic [DEV_W-1:0] dev;
  logic [CMD_W-1:0] cmd;
  logic [PAY_W-1:0] pay;

  assign dev     = req[WORD_W-1 -: DEV_W];
  assign cmd     = req[WORD_W-DEV_W-1 -: CMD_W];
  assign pay     = req[PAY_W-1:0];
  assign code    = pay[PAY_W-1:1];
  assign tx_char = pay[CHAR_W-1:0];

  always_comb begin
    act  = ACT_REPLY;
    resp = '0;
    if (dev == DEV_EXIT && cmd == CMD_ZERO && pay[0]) begin
      act = ACT_EXIT;
    end else if (dev == DEV_CONSOLE && cmd == CMD_ONE) begin
      act  = ACT_TX;
      resp = PAY_W'(ack_char(pay[CHAR_W-1:0]));
    end else if (dev == DEV_CONSOLE && cmd == CMD_ZERO) begin
      act = ACT_ARM;
    end
  end
endmodule

// File: rtl/hmb_read_mux.sv
module hmb_read_mux
  import hmb_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 4,
  localparam int WORD_W = 2 * BUS_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] req_word,
  input  logic [WORD_W-1:0] rep_word,
  output logic [BUS_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_REQ_LO))      rdata = req_word[BUS_W-1:0];
    else if (addr == ADDR_W'(OFS_REQ_HI)) rdata = req_word[WORD_W-1:BUS_W];
    else if (addr == ADDR_W'(OFS_REP_LO)) rdata = rep_word[BUS_W-1:0];
    else if (addr == ADDR_W'(OFS_REP_HI)) rdata = rep_word[WORD_W-1:BUS_W];
  end
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import hmb_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 4,
  localparam int WORD_W = 2 * BUS_W,
  localparam int PAY_W  = WORD_W - DEV_W - CMD_W,
  localparam int TOP_W  = DEV_W + CMD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              con_rx_valid,
  input  logic [CHAR_W-1:0] con_rx_byte,
  output logic              con_tx_valid,
  output logic [CHAR_W-1:0] con_tx_byte,
  output logic              exit_valid,
  output logic [PAY_W-2:0]  exit_code
);
  logic [WORD_W-1:0] req_q, rep_q, pend_q;
  logic              allow_q;

  // named internal events
  logic wr_req_lo, wr_req_hi, wr_rep_lo, wr_rep_hi;
  logic proc_fire;
  logic [WORD_W-1:0] req_merged;
  hmb_act_e          act;
  logic [PAY_W-1:0]  resp;
  logic [PAY_W-2:0]  dec_code;
  logic [CHAR_W-1:0] dec_char;
  logic [WORD_W-1:0] rx_reply;

  assign wr_req_lo  = bus_wr && bus_addr == ADDR_W'(OFS_REQ_LO);
  assign wr_req_hi  = bus_wr && bus_addr == ADDR_W'(OFS_REQ_HI);
  assign wr_rep_lo  = bus_wr && bus_addr == ADDR_W'(OFS_REP_LO);
  assign wr_rep_hi  = bus_wr && bus_addr == ADDR_W'(OFS_REP_HI);
  assign req_merged = req_q | {bus_wdata, {BUS_W{1'b0}}};
  assign proc_fire  = wr_req_hi && allow_q;
  assign rx_reply   = {pend_q[WORD_W-1 -: TOP_W], PAY_W'(ack_char(con_rx_byte))};

  hmb_req_decode #(.WORD_W(WORD_W)) u_dec (
    .req     (req_merged),
    .act     (act),
    .resp    (resp),
    .code    (dec_code),
    .tx_char (dec_char)
  );

  hmb_read_mux #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_rd (
    .addr     (bus_addr),
    .req_word (req_q),
    .rep_word (rep_q),
    .rdata    (bus_rdata)
  );

  // request register, commit permission and armed read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= '0;
      pend_q  <= '0;
      allow_q <= 1'b0;
    end else if (wr_req_lo) begin
      if (req_q == '0) begin
        req_q   <= {{BUS_W{1'b0}}, bus_wdata};
        allow_q <= 1'b1;
      end else begin
        allow_q <= 1'b0;
      end
    end else if (wr_req_hi) begin
      if (allow_q) begin
        req_q <= '0;
        if (act == ACT_ARM) pend_q <= req_merged;
      end else begin
        req_q <= req_merged;
      end
    end
  end

  // reply register: arriving character has top priority
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_q <= '0;
    end else if (con_rx_valid) begin
      rep_q <= rx_reply;
    end else if (proc_fire && act != ACT_ARM) begin
      rep_q <= {req_merged[WORD_W-1 -: TOP_W], resp};
    end else if (wr_rep_lo) begin
      rep_q <= {{BUS_W{1'b0}}, bus_wdata};
    end else if (wr_rep_hi) begin
      rep_q <= rep_q | {bus_wdata, {BUS_W{1'b0}}};
    end
  end

  // one-cycle output pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      con_tx_valid <= 1'b0;
      con_tx_byte  <= '0;
      exit_valid   <= 1'b0;
      exit_code    <= '0;
    end else begin
      con_tx_valid <= proc_fire && act == ACT_TX;
      exit_valid   <= proc_fire && act == ACT_EXIT;
      if (proc_fire && act == ACT_TX)   con_tx_byte <= dec_char;
      if (proc_fire && act == ACT_EXIT) exit_code   <= dec_code;
    end
  end
endmodule

// File: rtl/hmb_chk.sv
module hmb_chk #(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 4,
  localparam int WORD_W = 2 * BUS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              con_rx_valid,
  input logic [7:0]        con_rx_byte,
  input logic              con_tx_valid,
  input logic              exit_valid,
  input logic              proc_fire,
  input logic              allow_q,
  input logic [WORD_W-1:0] req_q,
  input logic [WORD_W-1:0] rep_q
);
  // R5
  exit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid |=> !exit_valid);

  // R5
  exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid |-> $past(proc_fire));

  // R6
  tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    con_tx_valid |-> $past(proc_fire));

  // R2
  req_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proc_fire |=> req_q == '0);

  // R3
  lo_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && req_q != '0) |=> $stable(req_q));

  // R4
  hi_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(4) && !allow_q) |=> (!con_tx_valid && !exit_valid));

  // R9
  rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    con_rx_valid |=> rep_q[8:0] == {1'b1, $past(con_rx_byte)});
endmodule

bind host_mailbox hmb_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .con_rx_valid (con_rx_valid),
  .con_rx_byte  (con_rx_byte),
  .con_tx_valid (con_tx_valid),
  .exit_valid   (exit_valid),
  .proc_fire    (proc_fire),
  .allow_q      (allow_q),
  .req_q        (req_q),
  .rep_q        (rep_q)
);

// File: tb/host_mailbox_test.sv
`timescale 1ns/1ps
module host_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        con_rx_valid = 1'b0;
  logic [7:0]  con_rx_byte = '0;
  logic        con_tx_valid;
  logic [7:0]  con_tx_byte;
  logic        exit_valid;
  logic [46:0] exit_code;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // bench model
  logic [63:0] m_req, m_rep, m_pend;
  bit          m_allow;
  bit          e_tx, e_exit;
  logic [7:0]  e_char;
  logic [46:0] e_code;

  always #2 clk = ~clk;

  host_mailbox uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .con_rx_valid(con_rx_valid), .con_rx_byte(con_rx_byte),
    .con_tx_valid(con_tx_valid), .con_tx_byte(con_tx_byte),
    .exit_valid(exit_valid), .exit_code(exit_code)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // model of one bus write
  task automatic model_write(input logic [3:0] a, input logic [31:0] d);
    logic [63:0] full;
    logic [7:0]  dv, cm;
    logic [47:0] pl, rs;
    e_tx = 0; e_exit = 0;
    case (a)
      4'h0: begin
        if (m_req == 64'd0) begin m_req = 64'(d); m_allow = 1; end
        else m_allow = 0;
      end
      4'h4: begin
        full = m_req | (64'(d) << 32);
        if (!m_allow) m_req = full;
        else begin
          dv = full[63:56]; cm = full[55:48]; pl = full[47:0];
          m_req = 64'd0;
          if (dv == 8'd1 && cm == 8'd0) m_pend = full;
          else begin
            rs = 48'd0;
            if (dv == 8'd0 && cm == 8'd0 && pl[0]) begin
              e_exit = 1; e_code = 47'(pl / 2);
            end
            if (dv == 8'd1 && cm == 8'd1) begin
              e_tx = 1; e_char = pl[7:0]; rs = 48'd256 + 48'(pl % 256);
            end
            m_rep = {full[63:48], rs};
          end
        end
      end
      4'h8: m_rep = 64'(d);
      4'hC: m_rep = m_rep | (64'(d) << 32);
      default: ;
    endcase
  endtask

  task automatic check_pulses(input string tag);
    chk({tag, " exit_valid"}, 64'(exit_valid), 64'(e_exit));
    chk({tag, " tx_valid"}, 64'(con_tx_valid), 64'(e_tx));
    if (e_exit) chk({tag, " exit_code"}, 64'(exit_code), 64'(e_code));
    if (e_tx)   chk({tag, " tx_byte"}, 64'(con_tx_byte), 64'(e_char));
    if (e_tx || e_exit) begin
      @(posedge clk); #1;
      chk({tag, " pulse width"}, 64'({exit_valid, con_tx_valid}), 64'd0);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic check_regs(input string tag);
    logic [31:0] v;
    rd(4'h0, v); chk({tag, " req lo"}, 64'(v), 64'(m_req[31:0]));
    rd(4'h4, v); chk({tag, " req hi"}, 64'(v), 64'(m_req[63:32]));
    rd(4'h8, v); chk({tag, " rep lo"}, 64'(v), 64'(m_rep[31:0]));
    rd(4'hC, v); chk({tag, " rep hi"}, 64'(v), 64'(m_rep[63:32]));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    model_write(a, d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
    check_pulses(tag);
  endtask

  // character arrival, optionally with a reply-register write in the same cycle
  task automatic rx(input logic [7:0] b, input bit with_wr, input logic [3:0] a,
                    input logic [31:0] d, input string tag);
    e_tx = 0; e_exit = 0;
    if (with_wr) model_write(a, d);
    m_rep = {m_pend[63:48], 48'd256 + 48'(b)};
    @(negedge clk);
    con_rx_valid = 1; con_rx_byte = b;
    if (with_wr) begin bus_wr = 1; bus_addr = a; bus_wdata = d; end
    @(posedge clk); #1;
    con_rx_valid = 0; bus_wr = 0;
    check_regs(tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    m_req = '0; m_rep = '0; m_pend = '0; m_allow = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    logic [47:0] pays [4];
    string tg;
    pays[0] = 48'h0; pays[1] = 48'h1;
    pays[2] = 48'hABCD_1234_5679; pays[3] = 48'h8000_0000_00FE;

    do_reset();
    // R1 reset state
    check_regs("R1");
    chk("R1 outputs", 64'({exit_valid, con_tx_valid}), 64'd0);

    // R4 high half with no permission just merges
    wr(4'h4, 32'h0000_0001, "R4");
    check_regs("R4");
    // R3 low half refused while request nonzero
    wr(4'h0, 32'h0000_0001, "R3");
    check_regs("R3");
    wr(4'h4, 32'h0001_0000, "R4 blocked");
    check_regs("R4 blocked");

    do_reset();
    // sweep of devices, commands and payloads: R2 R5 R6 R7 R8
    for (int dv = 0; dv < 4; dv++)
      for (int cm = 0; cm < 4; cm++)
        for (int pi = 0; pi < 4; pi++) begin
          if (dv == 0 && cm == 0 && pays[pi][0]) tg = "R5";
          else if (dv == 1 && cm == 1) tg = "R6";
          else if (dv == 1 && cm == 0) tg = "R7";
          else tg = "R8";
          wr(4'h0, pays[pi][31:0], tg);
          wr(4'h4, {8'(dv), 8'(cm), pays[pi][47:32]}, tg);
          check_regs({tg, " R2"});
        end

    // R10 direct reply writes
    wr(4'h8, 32'hDEAD_BEEF, "R10");
    check_regs("R10 lo");
    wr(4'hC, 32'h1234_0000, "R10");
    check_regs("R10 hi");
    wr(4'hC, 32'h0000_5678, "R10");
    check_regs("R10 or");

    // R9 arm then receive
    wr(4'h0, 32'h0000_0042, "R7");
    wr(4'h4, 32'h0100_0077, "R7");
    check_regs("R7 arm");
    rx(8'h5A, 0, 4'h0, 32'h0, "R9");
    rx(8'hC3, 1, 4'h8, 32'hFFFF_FFFF, "R9 priority");
    rx(8'h00, 1, 4'hC, 32'hFFFF_FFFF, "R9 priority hi");

    // R11 unmapped addresses
    wr(4'h0, 32'h0000_1111, "R11");
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4 && a != 8 && a != 12) begin
        rd(4'(a), v);
        chk("R11 unmapped read", 64'(v), 64'd0);
      end
    end
    wr(4'h2, 32'hFFFF_FFFF, "R11");
    wr(4'hF, 32'hFFFF_FFFF, "R11");
    check_regs("R11 ignored write");

    // R3 refusal of a second low write clears permission
    wr(4'h0, 32'h0000_2222, "R3");
    check_regs("R3 refused");
    wr(4'h4, 32'h0101_0000, "R3 no commit");
    check_regs("R3 no commit");

    finished = 1;
    summary();
  end
endmodule